// File: doc/BRIEF.md
# Serial Configuration Register Port

This block lets an external controller read and write a small file of 8-bit configuration registers over a four-wire serial link: an active-low frame enable, a shift clock, serial data in, and serial data out with a separate output enable for a three-state pad. Every frame carries one direction bit, a 3-bit register address and eight data bits, most significant bit first. The register contents drive the rest of the device as one flat parallel bus. What the individual bits control is decided by the blocks that read that bus.

The serial lines come from outside the chip. They are synchronised into the system clock domain and the shift clock edges are found by oversampling, so the system clock must run several times faster than the shift clock. A write takes effect only when a complete frame has arrived under one enable window. A read drives the addressed register onto the data-out line during the eight data clocks and leaves the line undriven at all other times. The power-management inputs can clear the whole file when the device enters its full standby state.

Top module: `serctl_port`

## Requirements
- R1: A frame is sampled on rising shift-clock edges while `sen_n` is low, in this order: direction bit (1 = write, 0 = read), address bits A2, A1, A0, then data bits B7 down to B0.
- R2: The file holds NUM_REGS (default 6) registers at addresses 0 to NUM_REGS-1. Register k appears on `cfg_regs[8k+7:8k]`, and a complete write frame stores its data there.
- R3: Every register bit is 0 after `rst_n` is low at a clock edge, and also after any edge where `comm_mode` is 0 and `mod_enable` is 1 (full standby clear).
- R4: Bits that have no storage always read and drive as 0. These are bits 3:0 of register 2 and bits 2:0 of registers 3 and 4.
- R5: In a read frame, `sdo_oe` rises after the falling shift-clock edge that follows A0 and falls after the falling edge that follows B0. `sdo` carries B7..B0, one bit for each of the eight data rising edges.
- R6: `sdo_oe` is 0 in write frames, in the address phase of read frames, and while `sen_n` is high.
- R7: If `sen_n` rises before the twelfth shift clock, the frame is dropped and no register changes. The next frame starts again from the direction bit.
- R8: Writes to addresses NUM_REGS..7 change nothing, and reads of those addresses return 0.
- R9: Shift clocks after the twelfth within one enable window are ignored and do not alter the data written.
- R10: With `comm_mode` and `mod_enable` both 0, the registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times the shift-clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| comm_mode | input | 1 | 1 = communication mode, 0 = standby |
| mod_enable | input | 1 | Modulator power request; with comm_mode=0 this clears the file |
| sen_n | input | 1 | Active-low frame enable (asynchronous) |
| sclk | input | 1 | Serial shift clock (asynchronous) |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the sdo pad; the pad is undriven when 0 |
| cfg_regs | output | 8*NUM_REGS | Register contents, register k at bits 8k+7:8k |

## Verification
The bench builds the block with its defaults: six registers and two synchroniser stages. Two addresses, 6 and 7, therefore have no register behind them, so R8 is exercised through normal frames. Register 5 is the last one implemented and sits right beside the unimplemented range. The shift clock runs at twelve system clocks per period, which gives each edge ample margin after the synchroniser delay, so every output-enable and data transition can be sampled at the shift-clock edges alone.

// File: rtl/scp_pkg.sv
// Package: shared constants and the per-register storage mask for the
// serial configuration port. Assumes 3-bit addresses and 8-bit registers.
package scp_pkg;
    localparam int REG_W     = 8;
    localparam int ADDR_W    = 3;
    localparam int FRAME_LEN = 1 + ADDR_W + REG_W;
    localparam int CNT_W     = $clog2(FRAME_LEN + 1);

    // Bits that hold storage in register idx; the rest read as zero.
    function automatic logic [REG_W-1:0] reg_wmask(input int idx);
        case (idx)
            2:       return 8'hF0;
            3, 4:    return 8'hF8;
            default: return 8'hFF;
        endcase
    endfunction
endpackage

// File: rtl/scp_sync.sv
// Module: multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes STAGES >= 2; each bit is synchronised independently.
module scp_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] pipe;

    // Shift the raw inputs through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
        end else begin
            pipe[0] <= din;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
        end
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/scp_frame.sv
// Module: serial frame engine. Finds shift-clock edges in the synchronised
// inputs, collects direction, address and data bits on rising edges, issues a
// one-cycle write strobe after the last bit, and shifts read data out on
// falling edges. Assumes inputs are already synchronised to clk.
module scp_frame
    import scp_pkg::*;
#(
    parameter int NUM_REGS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sen_s,
    input  logic              sclk_s,
    input  logic              sdi_s,
    input  logic [REG_W-1:0]  rd_data,
    output logic [ADDR_W-1:0] addr,
    output logic              wr_strobe,
    output logic [REG_W-1:0]  wr_data,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam logic [CNT_W-1:0] C_ADDR_END = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] C_DATA0    = CNT_W'(ADDR_W + 1);
    localparam logic [CNT_W-1:0] C_LAST     = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] C_END      = CNT_W'(FRAME_LEN);

    logic              sclk_q;
    logic              rise, fall, active, mapped;
    logic [CNT_W-1:0]  cnt;
    logic              is_write;
    logic [ADDR_W-1:0] addr_q;
    logic [REG_W-1:0]  in_sh;
    logic [REG_W-1:0]  out_sh;

    // Remember the previous shift-clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end

    assign rise   = sclk_s & ~sclk_q;
    assign fall   = ~sclk_s & sclk_q;
    assign active = ~sen_s;
    assign mapped = {1'b0, addr_q} < (ADDR_W+1)'(NUM_REGS);

    // Frame sequencing: bit capture, write commit and read shift-out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            is_write  <= 1'b0;
            addr_q    <= '0;
            in_sh     <= '0;
            out_sh    <= '0;
            wr_strobe <= 1'b0;
            wr_data   <= '0;
            sdo_oe    <= 1'b0;
        end else begin
            wr_strobe <= 1'b0;
            if (!active) begin
                cnt    <= '0;
                sdo_oe <= 1'b0;
            end else if (rise && cnt < C_END) begin
                cnt <= cnt + 1'b1;
                if (cnt == '0)              is_write <= sdi_s;
                else if (cnt <= C_ADDR_END) addr_q   <= {addr_q[ADDR_W-2:0], sdi_s};
                else                        in_sh    <= {in_sh[REG_W-2:0], sdi_s};
                if (cnt == C_LAST && is_write && mapped) begin
                    wr_strobe <= 1'b1;
                    wr_data   <= {in_sh[REG_W-2:0], sdi_s};
                end
            end else if (fall && !is_write) begin
                if (cnt == C_DATA0) begin
                    out_sh <= rd_data;
                    sdo_oe <= 1'b1;
                end else if (cnt > C_DATA0 && cnt < C_END) begin
                    out_sh <= {out_sh[REG_W-2:0], 1'b0};
                end else if (cnt == C_END) begin
                    sdo_oe <= 1'b0;
                end
            end
        end
    end

    assign addr = addr_q;
    assign sdo  = sdo_oe & out_sh[REG_W-1];
endmodule

// File: rtl/scp_regfile.sv
// Module: configuration register file with per-register storage masks,
// a standby clear and a zero-filling read mux for unimplemented addresses.
// Assumes NUM_REGS <= 2**ADDR_W.
module scp_regfile
    import scp_pkg::*;
#(
    parameter int NUM_REGS = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [REG_W-1:0]          wr_data,
    output logic [REG_W-1:0]          rd_data,
    output logic [NUM_REGS*REG_W-1:0] cfg_flat
);
    logic [REG_W-1:0] regs [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        // Hold one register; clear has priority over a write.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                regs[i] <= '0;
            else if (wr_en && addr == ADDR_W'(i))
                regs[i] <= wr_data & reg_wmask(i);
        end
        assign cfg_flat[i*REG_W +: REG_W] = regs[i];
    end

    // Select the addressed register, zero for unimplemented addresses.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (addr == ADDR_W'(i)) rd_data = regs[i];
    end
endmodule

// File: rtl/serctl_port.sv
// Module: top of the serial configuration port. Synchronises the serial
// lines, runs the frame engine and holds the register file. Assumes clk is
// at least four times the shift-clock rate.
module serctl_port
    import scp_pkg::*;
#(
    parameter int NUM_REGS    = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      comm_mode,
    input  logic                      mod_enable,
    input  logic                      sen_n,
    input  logic                      sclk,
    input  logic                      sdi,
    output logic                      sdo,
    output logic                      sdo_oe,
    output logic [NUM_REGS*REG_W-1:0] cfg_regs
);
    logic              sen_s, sclk_s, sdi_s;
    logic              clr_req;
    logic              wr_strobe;
    logic [ADDR_W-1:0] addr;
    logic [REG_W-1:0]  wr_data;
    logic [REG_W-1:0]  rd_data;

    assign clr_req = ~comm_mode & mod_enable;

    scp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sen_n, sclk, sdi}),
        .dout ({sen_s, sclk_s, sdi_s})
    );

    scp_frame #(.NUM_REGS(NUM_REGS)) frame_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sen_s    (sen_s),
        .sclk_s   (sclk_s),
        .sdi_s    (sdi_s),
        .rd_data  (rd_data),
        .addr     (addr),
        .wr_strobe(wr_strobe),
        .wr_data  (wr_data),
        .sdo      (sdo),
        .sdo_oe   (sdo_oe)
    );

    scp_regfile #(.NUM_REGS(NUM_REGS)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_req),
        .wr_en   (wr_strobe),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .cfg_flat(cfg_regs)
    );
endmodule

// File: rtl/serctl_port_chk.sv
// Module: property checker for the serial configuration port, attached to
// every serctl_port instance by the bind below.
module serctl_port_chk
    import scp_pkg::*;
#(
    parameter int NUM_REGS = 6
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      clr_req,
    input logic                      sen_s,
    input logic                      sdo_oe,
    input logic                      wr_strobe,
    input logic [ADDR_W-1:0]         addr,
    input logic [NUM_REGS*REG_W-1:0] cfg_regs
);
    // R3: a standby clear empties the file on the next cycle.
    a_r3_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> cfg_regs == '0);

    // R4: bits without storage never show a 1.
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_mask
        a_r4_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_regs[i*REG_W +: REG_W] & ~reg_wmask(i)) == '0);
    end

    // R6: the output is released once the enable is seen inactive.
    a_r6_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        sen_s |=> !sdo_oe);

    // R8: the engine never strobes a write toward an unimplemented address.
    a_r8_strobe_mapped: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> ({1'b0, addr} < (ADDR_W+1)'(NUM_REGS)));

    // R7, R10: without a strobe or clear the file holds still.
    a_r7_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_strobe && !clr_req) |=> $stable(cfg_regs));
endmodule

bind serctl_port serctl_port_chk #(.NUM_REGS(NUM_REGS)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_req  (clr_req),
    .sen_s    (sen_s),
    .sdo_oe   (sdo_oe),
    .wr_strobe(wr_strobe),
    .addr     (addr),
    .cfg_regs (cfg_regs)
);

// File: tb/serctl_port_tb_top.sv
// Bench: walks a table of write/read frames against a bench-side model,
// then runs directed checks for reset, abort, extra clocks and standby.
module serctl_port_tb_top;
    localparam int NREG = 6;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic comm_mode = 1'b1;
    logic mod_enable = 1'b1;
    logic sen_n = 1'b1;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic sdo, sdo_oe;
    logic [NREG*8-1:0] cfg_regs;

    int n_chk = 0;
    int n_bad = 0;
    logic finished = 1'b0;
    logic [7:0] model [NREG];

    always #5 clk = ~clk;

    serctl_port dut_i (
        .clk(clk), .rst_n(rst_n), .comm_mode(comm_mode), .mod_enable(mod_enable),
        .sen_n(sen_n), .sclk(sclk), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe),
        .cfg_regs(cfg_regs)
    );

    // {write, addr[2:0], data[7:0], expected[7:0]}
    localparam logic [19:0] VECS [16] = '{
        {1'b1, 3'd0, 8'hA5, 8'hA5}, {1'b0, 3'd0, 8'h00, 8'hA5},
        {1'b1, 3'd1, 8'hFF, 8'hFF}, {1'b1, 3'd2, 8'hFF, 8'hF0},
        {1'b0, 3'd2, 8'h00, 8'hF0}, {1'b1, 3'd3, 8'hFF, 8'hF8},
        {1'b0, 3'd3, 8'h00, 8'hF8}, {1'b1, 3'd4, 8'h5A, 8'h58},
        {1'b0, 3'd4, 8'h00, 8'h58}, {1'b1, 3'd5, 8'h3C, 8'h3C},
        {1'b0, 3'd5, 8'h00, 8'h3C}, {1'b1, 3'd6, 8'h77, 8'h00},
        {1'b0, 3'd6, 8'h00, 8'h00}, {1'b1, 3'd7, 8'h11, 8'h00},
        {1'b0, 3'd7, 8'h00, 8'h00}, {1'b0, 3'd1, 8'h00, 8'hFF}
    };

    // Storage mask per R4.
    function automatic logic [7:0] mask_of(input int a);
        if (a == 2) return 8'hF0;
        if (a == 3 || a == 4) return 8'hF8;
        return 8'hFF;
    endfunction

    function automatic logic [NREG*8-1:0] model_flat();
        logic [NREG*8-1:0] f;
        for (int i = 0; i < NREG; i++) f[i*8 +: 8] = model[i];
        return f;
    endfunction

    task automatic check(input logic ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One enable window with nbits shift clocks; returns the read byte and
    // whether sdo_oe followed the R5/R6 window at every rising edge.
    task automatic frame(input logic wr, input logic [2:0] a, input logic [7:0] d,
                         input int nbits, output logic [7:0] got, output logic win_ok);
        logic [13:0] stream;
        stream = {wr, a, d, 2'b11};
        got = '0;
        win_ok = 1'b1;
        sen_n = 1'b0;
        wait_clk(HALF);
        for (int b = 0; b < nbits; b++) begin
            sdi = stream[13-b];
            wait_clk(HALF);
            if (sdo_oe !== (!wr && b >= 4 && b < 12)) win_ok = 1'b0;
            if (b >= 4 && b < 12) got = {got[6:0], sdo};
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
        wait_clk(HALF);
        if (sdo_oe !== 1'b0) win_ok = 1'b0;
        sen_n = 1'b1;
        wait_clk(8);
    endtask

    initial begin
        logic [7:0] got;
        logic ok;
        for (int i = 0; i < NREG; i++) model[i] = '0;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        check(cfg_regs == '0, "R3 reset state", 64'(cfg_regs), 64'd0);
        check(sdo_oe == 1'b0, "R6 idle oe", 64'(sdo_oe), 64'd0);

        // Table walk: R1, R2, R4, R5, R6, R8.
        for (int v = 0; v < 16; v++) begin
            logic wr;
            logic [2:0] a;
            logic [7:0] d, e;
            {wr, a, d, e} = VECS[v];
            frame(wr, a, d, 12, got, ok);
            check(ok, "R5/R6 oe window", 64'(ok), 64'd1);
            if (wr) begin
                if (a < NREG) begin
                    model[a] = d & mask_of(a);
                    check(cfg_regs[a*8 +: 8] == e, "R2/R4 write value",
                          64'(cfg_regs[a*8 +: 8]), 64'(e));
                end
                check(cfg_regs == model_flat(), "R1/R8 file after write",
                      64'(cfg_regs), 64'(model_flat()));
            end else begin
                check(got == e, "R5/R8 read data", 64'(got), 64'(e));
            end
        end

        // R7: aborted write leaves file unchanged, next frame starts clean.
        frame(1'b1, 3'd0, 8'h33, 8, got, ok);
        check(cfg_regs == model_flat(), "R7 abort no write", 64'(cfg_regs), 64'(model_flat()));
        frame(1'b0, 3'd0, 8'h00, 12, got, ok);
        check(got == 8'hA5, "R7 fresh frame after abort", 64'(got), 64'hA5);

        // R9: two extra clocks with 1s do not disturb the written data.
        frame(1'b1, 3'd1, 8'h12, 14, got, ok);
        model[1] = 8'h12;
        check(cfg_regs[15:8] == 8'h12, "R9 extra clocks", 64'(cfg_regs[15:8]), 64'h12);
        frame(1'b0, 3'd1, 8'h00, 14, got, ok);
        check(got == 8'h12 && ok, "R9 read with extra clocks", 64'(got), 64'h12);

        // R10: standby with modulator off keeps the file.
        comm_mode = 1'b0;
        mod_enable = 1'b0;
        wait_clk(5);
        check(cfg_regs == model_flat(), "R10 standby retains", 64'(cfg_regs), 64'(model_flat()));
        // R3: full standby clear.
        mod_enable = 1'b1;
        wait_clk(3);
        check(cfg_regs == '0, "R3 standby clear", 64'(cfg_regs), 64'd0);
        comm_mode = 1'b1;
        wait_clk(3);

        // R3: reset clears a written register.
        frame(1'b1, 3'd5, 8'h81, 12, got, ok);
        check(cfg_regs[47:40] == 8'h81, "R2 write before reset", 64'(cfg_regs[47:40]), 64'h81);
        rst_n = 1'b0;
        wait_clk(2);
        rst_n = 1'b1;
        wait_clk(2);
        check(cfg_regs == '0, "R3 reset clears", 64'(cfg_regs), 64'd0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule